// File: doc/BRIEF.md
# Timer Control Word Decoder

This block sits behind the command port of a three-channel programmable interval timer. Each byte written to that port is split into fields and turned into per-channel actions. A byte either stores a new access and operating mode into one channel, or freezes one channel's current count, or runs a multi-channel read-back that can freeze the count, the status, or both on any set of channels at once. The counters themselves, and the address decode that produces the write strobe, sit outside this block.

All actions leave the block as one-cycle strobes, one bit per channel, registered on the clock edge that samples the write. The byte to be stored is presented on a held output next to the store strobe. Before it is stored, the byte is normalised so that the two aliased operating-mode encodings reach the channel as their canonical values.

Top module: `pit_cw_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all strobes are 0 and `store_word` is 8'h00.
- R2: A cycle with `cw_wr` low produces no strobe in the following cycle, and every strobe is high for exactly one cycle per write.
- R3: A write with bits 7:6 equal to 00, 01 or 10 (channel 0, 1 or 2) and bits 5:4 not 00 raises `store_stb` for that channel only, one cycle later. `store_word` takes the written byte in that same cycle.
- R4: A write with bits 7:6 selecting a channel and bits 5:4 equal to 00 raises `cnt_latch_stb` for that channel only, one cycle later. It raises no store strobe and leaves `store_word` unchanged.
- R5: A write with bits 7:6 equal to 11 is a read-back. Bits 1, 2 and 3 pick channels 0, 1 and 2 in any combination, and bit 0 is ignored. A read-back that picks no channel does nothing.
- R6: In a read-back, bit 5 is an active-low count enable and bit 4 is an active-low status enable. Bits 5:4 equal to 01 latch only the count, and 10 latch only the status, on each picked channel.
- R7: A read-back with bits 5:4 equal to 00 raises both `cnt_latch_stb` and `sts_latch_stb` in the same cycle for each picked channel. The channel then returns status before count.
- R8: A read-back with bits 5:4 equal to 11 raises no strobe.
- R9: A stored byte whose mode field (bits 3:1) is 110 or 111 reaches `store_word` with bit 3 cleared, as mode 010 or 011. All other bits pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_wr | input | 1 | Write strobe for the command port |
| cw_data | input | 8 | Control byte being written |
| store_stb | output | 3 | Per-channel pulse: take `store_word` as the new command |
| cnt_latch_stb | output | 3 | Per-channel pulse: freeze the current count |
| sts_latch_stb | output | 3 | Per-channel pulse: freeze the status byte |
| store_word | output | 8 | Normalised command byte, held until the next store |

## Verification
A wrongly decoded field shows up at the ports in the cycle right after the write. It appears as a strobe on the wrong channel, a missing strobe, an inverted read-back enable, or a store mistaken for a latch. A corrupted held byte stays visible on `store_word` in every cycle until the next store, so the per-clock comparison against the reference model exposes it at once. A strobe that lasts longer than one cycle is caught by the idle cycles that follow each write.

// File: rtl/pit_cw_pkg.sv
package pit_cw_pkg;

   localparam int CW_W = 8;

   typedef enum logic [1:0] {
      ACC_FREEZE = 2'b00,
      ACC_LO     = 2'b01,
      ACC_HI     = 2'b10,
      ACC_LOHI   = 2'b11
   } acc_e;

   localparam logic [1:0] SEL_READBACK = 2'b11;

   typedef struct packed {
      logic [1:0] sel;
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } cw_t;

   typedef enum logic [1:0] {
      KIND_NONE,
      KIND_STORE,
      KIND_FREEZE,
      KIND_READBACK
   } cw_kind_e;

endpackage

// File: rtl/pit_cw_field_split.sv
module pit_cw_field_split
   import pit_cw_pkg::*;
#(
   parameter int  DATA_W     = 8,
   parameter bit  FOLD_MODES = 1'b1
) (
   input  logic              wr,
   input  logic [DATA_W-1:0] data,
   output cw_t               fields,
   output cw_kind_e          kind,
   output logic [DATA_W-1:0] norm_word
);

   if (DATA_W != CW_W) begin : g_bad_width
      $error("pit_cw_field_split: DATA_W must equal %0d", CW_W);
   end

   assign fields = cw_t'(data);

   always_comb begin
      if (!wr)                           kind = KIND_NONE;
      else if (fields.sel == SEL_READBACK) kind = KIND_READBACK;
      else if (fields.acc == ACC_FREEZE) kind = KIND_FREEZE;
      else                               kind = KIND_STORE;
   end

   if (FOLD_MODES) begin : g_fold
      logic [2:0] mode_fix;
      always_comb begin
         mode_fix = fields.mode;
         if (fields.mode[2:1] == 2'b11) mode_fix[2] = 1'b0;
      end
      assign norm_word = {fields.sel, fields.acc, mode_fix, fields.bcd};
   end else begin : g_raw
      assign norm_word = data;
   end

endmodule

// File: rtl/pit_cw_chan_decode.sv
module pit_cw_chan_decode
   import pit_cw_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  cw_t              fields,
   input  cw_kind_e         kind,
   output logic [NUM_CH-1:0] nxt_store,
   output logic [NUM_CH-1:0] nxt_cnt,
   output logic [NUM_CH-1:0] nxt_sts
);

   logic cnt_en_rb;
   logic sts_en_rb;

   assign cnt_en_rb = ~fields.acc[1];
   assign sts_en_rb = ~fields.acc[0];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic addressed;
      logic rb_pick;
      assign addressed = (fields.sel == 2'(ch));
      assign rb_pick   = (kind == KIND_READBACK) && fields.mode[ch];

      assign nxt_store[ch] = (kind == KIND_STORE)  && addressed;
      assign nxt_cnt[ch]   = ((kind == KIND_FREEZE) && addressed) ||
                             (rb_pick && cnt_en_rb);
      assign nxt_sts[ch]   = rb_pick && sts_en_rb;
   end

endmodule

// File: rtl/pit_cw_strobe_reg.sv
module pit_cw_strobe_reg #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] nxt_store,
   input  logic [NUM_CH-1:0] nxt_cnt,
   input  logic [NUM_CH-1:0] nxt_sts,
   input  logic [DATA_W-1:0] nxt_word,
   output logic [NUM_CH-1:0] store_q,
   output logic [NUM_CH-1:0] cnt_q,
   output logic [NUM_CH-1:0] sts_q,
   output logic [DATA_W-1:0] word_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_q <= '0;
         cnt_q   <= '0;
         sts_q   <= '0;
         word_q  <= '0;
      end else begin
         store_q <= nxt_store;
         cnt_q   <= nxt_cnt;
         sts_q   <= nxt_sts;
         if (|nxt_store) word_q <= nxt_word;
      end
   end

endmodule

// File: rtl/pit_cw_decoder.sv
module pit_cw_decoder
   import pit_cw_pkg::*;
#(
   parameter int NUM_CH     = 3,
   parameter int DATA_W     = 8,
   parameter bit FOLD_MODES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_wr,
   input  logic [DATA_W-1:0] cw_data,
   output logic [NUM_CH-1:0] store_stb,
   output logic [NUM_CH-1:0] cnt_latch_stb,
   output logic [NUM_CH-1:0] sts_latch_stb,
   output logic [DATA_W-1:0] store_word
);

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("pit_cw_decoder: NUM_CH must be 1 to 3");
   end

   cw_t               fields;
   cw_kind_e          kind;
   logic [DATA_W-1:0] norm_word;
   logic [NUM_CH-1:0] nxt_store;
   logic [NUM_CH-1:0] nxt_cnt;
   logic [NUM_CH-1:0] nxt_sts;

   pit_cw_field_split #(
      .DATA_W     (DATA_W),
      .FOLD_MODES (FOLD_MODES)
   ) u_split (
      .wr        (cw_wr),
      .data      (cw_data),
      .fields    (fields),
      .kind      (kind),
      .norm_word (norm_word)
   );

   pit_cw_chan_decode #(
      .NUM_CH (NUM_CH)
   ) u_chan (
      .fields    (fields),
      .kind      (kind),
      .nxt_store (nxt_store),
      .nxt_cnt   (nxt_cnt),
      .nxt_sts   (nxt_sts)
   );

   pit_cw_strobe_reg #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_store (nxt_store),
      .nxt_cnt   (nxt_cnt),
      .nxt_sts   (nxt_sts),
      .nxt_word  (norm_word),
      .store_q   (store_stb),
      .cnt_q     (cnt_latch_stb),
      .sts_q     (sts_latch_stb),
      .word_q    (store_word)
   );

endmodule

// File: rtl/pit_cw_decoder_chk.sv
module pit_cw_decoder_chk #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cw_wr,
   input logic [DATA_W-1:0] cw_data,
   input logic [NUM_CH-1:0] store_stb,
   input logic [NUM_CH-1:0] cnt_latch_stb,
   input logic [NUM_CH-1:0] sts_latch_stb,
   input logic [DATA_W-1:0] store_word
);

   logic is_rb;
   assign is_rb = cw_wr && (cw_data[7:6] == 2'b11);

   // R2: an idle cycle is followed by silence on every strobe
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cw_wr |=> (store_stb == '0 && cnt_latch_stb == '0 && sts_latch_stb == '0));

   // R3: at most one channel receives a store
   a_r3_store_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(store_stb));

   // R4: a store never coincides with a latch strobe
   a_r4_store_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (|store_stb) |-> (cnt_latch_stb == '0 && sts_latch_stb == '0));

   // R4: the held byte changes only together with a store strobe
   a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(|store_stb) |-> $stable(store_word));

   // R6: count-only read-back raises no status strobe
   a_r6_count_only: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rb && cw_data[5:4] == 2'b01) |=> (sts_latch_stb == '0));

   // R7: a both-enabled read-back latches count and status on the same channels
   a_r7_both_same: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rb && cw_data[5:4] == 2'b00) |=> (cnt_latch_stb == sts_latch_stb));

   // R8: a read-back with both enables off does nothing
   a_r8_rb_none: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rb && cw_data[5:4] == 2'b11) |=>
         (store_stb == '0 && cnt_latch_stb == '0 && sts_latch_stb == '0));

endmodule

bind pit_cw_decoder pit_cw_decoder_chk #(
   .NUM_CH (NUM_CH),
   .DATA_W (DATA_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cw_wr         (cw_wr),
   .cw_data       (cw_data),
   .store_stb     (store_stb),
   .cnt_latch_stb (cnt_latch_stb),
   .sts_latch_stb (sts_latch_stb),
   .store_word    (store_word)
);

// File: tb/pit_cw_decoder_tb.sv
module pit_cw_decoder_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cw_wr = 1'b0;
   logic [7:0] cw_data = 8'h00;
   logic [2:0] store_stb, cnt_latch_stb, sts_latch_stb;
   logic [7:0] store_word;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [7:0] m_word = 8'h00;

   always #10 clk = ~clk;

   pit_cw_decoder u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cw_wr         (cw_wr),
      .cw_data       (cw_data),
      .store_stb     (store_stb),
      .cnt_latch_stb (cnt_latch_stb),
      .sts_latch_stb (sts_latch_stb),
      .store_word    (store_word)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Drives one cycle starting at a falling edge and compares at the next one.
   task automatic step(input logic we, input logic [7:0] d);
      logic [2:0] e_st, e_cnt, e_sts;
      string      tag;
      int         sel, acc, md;
      e_st = '0; e_cnt = '0; e_sts = '0;
      sel = int'(d[7:6]); acc = int'(d[5:4]); md = int'(d[3:1]);
      cw_wr = we; cw_data = d;
      if (!we) tag = "R2";
      else if (sel == 3) begin
         if (acc == 3) tag = "R8";
         else if (acc == 0) tag = "R7";
         else tag = "R6";
         if (d[3:1] == 3'b000) tag = "R5";
         for (int ch = 0; ch < 3; ch++) begin
            if (d[ch+1]) begin
               if (!d[5]) e_cnt[ch] = 1'b1;
               if (!d[4]) e_sts[ch] = 1'b1;
            end
         end
      end else if (acc == 0) begin
         tag = "R4";
         e_cnt[sel] = 1'b1;
      end else begin
         tag = (md >= 6) ? "R9" : "R3";
         e_st[sel] = 1'b1;
         m_word = d;
         if (md >= 6) m_word[3] = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, "store_stb",     {5'b0, store_stb},     {5'b0, e_st});
      check(tag, "cnt_latch_stb", {5'b0, cnt_latch_stb}, {5'b0, e_cnt});
      check(tag, "sts_latch_stb", {5'b0, sts_latch_stb}, {5'b0, e_sts});
      check(tag, "store_word",    store_word,            m_word);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      // R1: reset dominates a write presented during reset
      @(negedge clk);
      cw_wr = 1'b1; cw_data = 8'h34;
      repeat (2) @(negedge clk);
      check("R1", "store_stb",     {5'b0, store_stb},     8'h00);
      check("R1", "cnt_latch_stb", {5'b0, cnt_latch_stb}, 8'h00);
      check("R1", "sts_latch_stb", {5'b0, sts_latch_stb}, 8'h00);
      check("R1", "store_word",    store_word,            8'h00);
      cw_wr = 1'b0;
      rst_n = 1'b1;
      step(1'b0, 8'h00);                 // R1/R2 first cycle after reset
      step(1'b1, 8'h34);                 // R3 ch0 lo/hi mode 2
      step(1'b0, 8'h00);                 // R2 pulse ends
      step(1'b1, 8'h72);                 // R3 ch1
      step(1'b1, 8'hB6);                 // R3 ch2, back to back
      step(1'b1, 8'h40);                 // R4 freeze ch1, word held
      step(1'b1, 8'h80);                 // R4 freeze ch2
      step(1'b1, 8'h3C);                 // R9 mode 6 -> 2
      step(1'b1, 8'h1E);                 // R9 mode 7 -> 3
      step(1'b1, 8'hDE);                 // R6 count only, all channels
      step(1'b1, 8'hE2);                 // R6 status only, ch0
      step(1'b1, 8'hCA);                 // R7 both, ch0 and ch2
      step(1'b1, 8'hC5);                 // R5 bit 0 ignored, ch1 both
      step(1'b1, 8'hFE);                 // R8 no action
      step(1'b1, 8'hC0);                 // R5 no channel picked
      step(1'b0, 8'hFF);                 // R2 data ignored without write
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[5], lfsr[15:8]);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule